// File: doc/BRIEF.md
# Debug Hart Selection and Reset-Acknowledge Tracker

This block holds the hart-selection part of a debug module's control word and the per-hart "has been reset" bookkeeping behind the status word. A debugger writes a 32-bit control word. The block rebuilds a hart index from two 10-bit select fields in that word and trims the index to the implemented select width. It also keeps the request bits that go out to the harts and returns all of these fields when the control word is read back.

Each hart has one sticky flag. The flag goes high when that hart signals a reset. It goes low when the debugger writes a control word that selects the hart with the acknowledge bit set. Two status outputs report the flag of the hart that is currently selected. When the module-active bit rises from 0 to 1 in a write, the block starts over and every flag is cleared.

Top module: `dbg_hartsel_tracker`

## Requirements
- R1: After reset the readback word, the selected index, every request output, module-active and both status bits are 0.
- R2: On a write with bit 0 set, the selected index becomes (word[15:6] << 10) | word[25:16], truncated to SEL_LEN bits (default 12).
- R3: The readback word returns the selected index with its low 10 bits at [25:16] and the index shifted right by 10 at [15:6]. It also returns halt request at bit 31, resume request at bit 30, hart reset at bit 29, system reset at bit 1 and module-active at bit 0. Bit 28 and all other bits read 0.
- R4: A write with bit 0 clear loads module-active with 0 and leaves the selected index and all four request bits unchanged.
- R5: A write that sets bit 0 while module-active is 0 clears every have-reset flag, except the flags of harts that pulse reset in that same cycle. The write's own fields are still loaded.
- R6: A reset pulse on hart N sets flag N in the next cycle.
- R7: A write with bits 0 and 28 both set clears the flag of the hart that the same write selects. All other flags are kept.
- R8: Both status outputs show the flag of the selected hart. Both read 0 when the selected index is NUM_HARTS or higher.
- R9: When hart N pulses reset in the same cycle that an acknowledge targets N, flag N ends up set.
- R10: A write with bit 28 set and bit 0 clear leaves every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word being written |
| hart_rst_pulse | input | NUM_HARTS | One-cycle reset indication per hart |
| sel_hart | output | SEL_LEN | Currently selected hart index |
| ctl_rdata | output | 32 | Control word readback |
| module_active | output | 1 | Stored module-active bit |
| halt_req | output | 1 | Stored halt request |
| resume_req | output | 1 | Stored resume request |
| hart_reset_req | output | 1 | Stored hart reset request |
| sys_reset_req | output | 1 | Stored system reset request |
| any_have_reset | output | 1 | Have-reset flag of the selected hart |
| all_have_reset | output | 1 | Have-reset flag of the selected hart |

## Verification
The status outputs only ever show one flag at a time, so the hardest case to reach is proving that an acknowledge or a restart left the unselected flags alone. The stimulus therefore pulses several harts, acknowledges one of them, and then moves the selection across the others with plain writes so that each surviving flag appears at the ports. The same walk covers the cases that collide in a single cycle: a reset pulse together with an acknowledge, and a reset pulse together with a restart. It also selects an index beyond the last implemented hart.

// File: rtl/dbg_sel_pkg.sv
package dbg_sel_pkg;
  localparam int unsigned CTL_W  = 32;
  localparam int unsigned LO_LSB = 16;
  localparam int unsigned LO_W   = 10;
  localparam int unsigned HI_LSB = 6;
  localparam int unsigned HI_W   = 10;
  localparam int unsigned IDX_W  = LO_W + HI_W;

  localparam int unsigned ACTIVE_BIT  = 0;
  localparam int unsigned SYSRST_BIT  = 1;
  localparam int unsigned ACK_BIT     = 28;
  localparam int unsigned HARTRST_BIT = 29;
  localparam int unsigned RESUME_BIT  = 30;
  localparam int unsigned HALT_BIT    = 31;

  typedef struct packed {
    logic halt;
    logic resume;
    logic hart_rst;
    logic sys_rst;
  } req_t;

  // Upper field sits above the lower field in the rebuilt index.
  function automatic logic [IDX_W-1:0] join_index(input logic [HI_W-1:0] hi,
                                                  input logic [LO_W-1:0] lo);
    logic [IDX_W-1:0] r;
    r = IDX_W'(hi) << LO_W;
    r = r | IDX_W'(lo);
    return r;
  endfunction

  function automatic logic [CTL_W-1:0] pack_ctl(input logic active,
                                                input req_t rq,
                                                input logic [IDX_W-1:0] idx);
    logic [CTL_W-1:0] w;
    logic [IDX_W-1:0] upper;
    w = '0;
    upper = idx >> LO_W;
    w[LO_LSB +: LO_W] = idx[LO_W-1:0];
    w[HI_LSB +: HI_W] = upper[HI_W-1:0];
    w[HALT_BIT]    = rq.halt;
    w[RESUME_BIT]  = rq.resume;
    w[HARTRST_BIT] = rq.hart_rst;
    w[SYSRST_BIT]  = rq.sys_rst;
    w[ACTIVE_BIT]  = active;
    return w;
  endfunction
endpackage

// File: rtl/dbg_ctl_decode.sv
module dbg_ctl_decode
  import dbg_sel_pkg::*;
#(
  parameter int unsigned SEL_LEN = 12
) (
  input  logic [CTL_W-1:0]   wdata,
  output logic               wr_active,
  output logic               wr_ack,
  output logic [SEL_LEN-1:0] wr_sel,
  output req_t               wr_req
);
  logic [IDX_W-1:0] full_idx;
  logic             unused_bits;

  always_comb begin
    full_idx        = join_index(wdata[HI_LSB +: HI_W], wdata[LO_LSB +: LO_W]);
    wr_sel          = SEL_LEN'(full_idx);
    wr_active       = wdata[ACTIVE_BIT];
    wr_ack          = wdata[ACK_BIT];
    wr_req.halt     = wdata[HALT_BIT];
    wr_req.resume   = wdata[RESUME_BIT];
    wr_req.hart_rst = wdata[HARTRST_BIT];
    wr_req.sys_rst  = wdata[SYSRST_BIT];
  end

  assign unused_bits = ^{wdata[5:2], wdata[27:26], full_idx};
endmodule

// File: rtl/dbg_ctl_regs.sv
module dbg_ctl_regs
  import dbg_sel_pkg::*;
#(
  parameter int unsigned SEL_LEN = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_active,
  input  logic [SEL_LEN-1:0] wr_sel,
  input  req_t               wr_req,
  output logic               active_q,
  output logic [SEL_LEN-1:0] sel_q,
  output req_t               req_q,
  output logic               load,
  output logic               restart
);
  assign load    = wr_en && wr_active;
  assign restart = load && !active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sel_q    <= '0;
      req_q    <= '0;
    end else if (wr_en) begin
      active_q <= wr_active;
      if (wr_active) begin
        sel_q <= wr_sel;
        req_q <= wr_req;
      end
    end
  end

  // R4: inactive writes keep selection and requests
  a_r4_inactive_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_active) |=> ($stable(sel_q) && $stable(req_q) && !active_q));
endmodule

// File: rtl/dbg_havereset_flags.sv
module dbg_havereset_flags #(
  parameter int unsigned NUM_HARTS = 8,
  parameter int unsigned SEL_LEN   = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 restart,
  input  logic                 ack_en,
  input  logic [SEL_LEN-1:0]   ack_sel,
  input  logic [NUM_HARTS-1:0] hart_rst,
  input  logic [SEL_LEN-1:0]   rd_sel,
  output logic [NUM_HARTS-1:0] flags_q,
  output logic                 sel_flag
);
  logic [NUM_HARTS-1:0] ack_hit;

  for (genvar i = 0; i < NUM_HARTS; i++) begin : g_hart
    assign ack_hit[i] = ack_en && (ack_sel == SEL_LEN'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flags_q[i] <= 1'b0;
      else if (hart_rst[i]) flags_q[i] <= 1'b1;
      else if (restart)     flags_q[i] <= 1'b0;
      else if (ack_hit[i])  flags_q[i] <= 1'b0;
    end

    // R6: a reset pulse raises the flag
    a_r6_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
      hart_rst[i] |=> flags_q[i]);
    // R7: acknowledge without a colliding pulse lowers the flag
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit[i] && !hart_rst[i]) |=> !flags_q[i]);
  end

  always_comb begin
    sel_flag = 1'b0;
    for (int i = 0; i < NUM_HARTS; i++)
      if (rd_sel == SEL_LEN'(i)) sel_flag = flags_q[i];
  end

  // R5: restart with no pulses leaves no flag set
  a_r5_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && hart_rst == '0) |=> (flags_q == '0));
endmodule

// File: rtl/dbg_hartsel_tracker.sv
module dbg_hartsel_tracker
  import dbg_sel_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 8,
  parameter int unsigned SEL_LEN   = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_wr_en,
  input  logic [31:0]          ctl_wdata,
  input  logic [NUM_HARTS-1:0] hart_rst_pulse,
  output logic [SEL_LEN-1:0]   sel_hart,
  output logic [31:0]          ctl_rdata,
  output logic                 module_active,
  output logic                 halt_req,
  output logic                 resume_req,
  output logic                 hart_reset_req,
  output logic                 sys_reset_req,
  output logic                 any_have_reset,
  output logic                 all_have_reset
);
  logic               wr_active, wr_ack, load, restart, sel_flag;
  logic [SEL_LEN-1:0] wr_sel, sel_q;
  req_t               wr_req, req_q;
  logic [NUM_HARTS-1:0] flags_q;

  dbg_ctl_decode #(.SEL_LEN(SEL_LEN)) u_dec (
    .wdata(ctl_wdata), .wr_active(wr_active), .wr_ack(wr_ack),
    .wr_sel(wr_sel), .wr_req(wr_req)
  );

  dbg_ctl_regs #(.SEL_LEN(SEL_LEN)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr_en), .wr_active(wr_active),
    .wr_sel(wr_sel), .wr_req(wr_req), .active_q(module_active),
    .sel_q(sel_q), .req_q(req_q), .load(load), .restart(restart)
  );

  dbg_havereset_flags #(.NUM_HARTS(NUM_HARTS), .SEL_LEN(SEL_LEN)) u_flags (
    .clk(clk), .rst_n(rst_n), .restart(restart), .ack_en(load && wr_ack),
    .ack_sel(wr_sel), .hart_rst(hart_rst_pulse), .rd_sel(sel_q),
    .flags_q(flags_q), .sel_flag(sel_flag)
  );

  assign sel_hart       = sel_q;
  assign ctl_rdata      = pack_ctl(module_active, req_q, IDX_W'(sel_q));
  assign halt_req       = req_q.halt;
  assign resume_req     = req_q.resume;
  assign hart_reset_req = req_q.hart_rst;
  assign sys_reset_req  = req_q.sys_rst;
  assign any_have_reset = sel_flag;
  assign all_have_reset = sel_flag;

  logic unused_flags;
  assign unused_flags = ^flags_q;
endmodule

// File: tb/sim_dbg_hartsel_tracker.sv
module sim_dbg_hartsel_tracker;
  localparam int NH = 8;
  localparam int SL = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctl_wr_en = 1'b0;
  logic [31:0]   ctl_wdata = '0;
  logic [NH-1:0] hart_rst_pulse = '0;
  logic [SL-1:0] sel_hart;
  logic [31:0]   ctl_rdata;
  logic module_active, halt_req, resume_req, hart_reset_req, sys_reset_req;
  logic any_have_reset, all_have_reset;

  always #5 clk = ~clk;

  dbg_hartsel_tracker #(.NUM_HARTS(NH), .SEL_LEN(SL)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wdata(ctl_wdata),
    .hart_rst_pulse(hart_rst_pulse), .sel_hart(sel_hart), .ctl_rdata(ctl_rdata),
    .module_active(module_active), .halt_req(halt_req), .resume_req(resume_req),
    .hart_reset_req(hart_reset_req), .sys_reset_req(sys_reset_req),
    .any_have_reset(any_have_reset), .all_have_reset(all_have_reset)
  );

  typedef struct {
    logic [31:0] rdata;
    int          sel;
    bit          flag;
    string       tag;
  } exp_t;
  exp_t q[$];

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  // reference state
  bit m_active, m_halt, m_res, m_hr, m_sr;
  int m_sel;
  bit m_flags[NH];

  function automatic logic [31:0] mkw(bit act, bit ack, bit halt, bit res,
                                      bit hr, bit sr, int hi, int lo);
    logic [31:0] w = '0;
    w[0] = act; w[28] = ack; w[31] = halt; w[30] = res; w[29] = hr; w[1] = sr;
    w[15:6]  = hi[9:0];
    w[25:16] = lo[9:0];
    return w;
  endfunction

  function automatic logic [31:0] model_word();
    logic [31:0] r = '0;
    int lo_part = m_sel % 1024;
    int hi_part = m_sel / 1024;
    r[31] = m_halt; r[30] = m_res; r[29] = m_hr; r[1] = m_sr; r[0] = m_active;
    r[25:16] = lo_part[9:0];
    r[15:6]  = hi_part[9:0];
    return r;
  endfunction

  task automatic step(input bit wr, input logic [31:0] w,
                      input logic [NH-1:0] p, input string tag);
    exp_t e;
    int ns;
    bit restart, ackon;
    @(negedge clk);
    ctl_wr_en = wr; ctl_wdata = w; hart_rst_pulse = p;
    @(posedge clk);
    ns = m_sel;
    if (wr && w[0]) ns = (int'(w[15:6]) * 1024 + int'(w[25:16])) % (1 << SL);
    restart = wr && w[0] && !m_active;
    ackon   = wr && w[0] && w[28];
    for (int h = 0; h < NH; h++) begin
      if (p[h]) m_flags[h] = 1'b1;
      else if (restart) m_flags[h] = 1'b0;
      else if (ackon && ns == h) m_flags[h] = 1'b0;
    end
    if (wr) begin
      m_active = w[0];
      if (w[0]) begin
        m_sel = ns; m_halt = w[31]; m_res = w[30]; m_hr = w[29]; m_sr = w[1];
      end
    end
    e.rdata = model_word();
    e.sel   = m_sel;
    e.flag  = (m_sel < NH) ? m_flags[m_sel] : 1'b0;
    e.tag   = tag;
    q.push_back(e);
    #1;
    ctl_wr_en = 1'b0; hart_rst_pulse = '0;
  endtask

  // monitor: compares at the falling edge after the expectation is queued
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_checks++;
      if (ctl_rdata !== e.rdata || int'(sel_hart) != e.sel ||
          any_have_reset !== e.flag || all_have_reset !== e.flag ||
          module_active !== e.rdata[0] || halt_req !== e.rdata[31] ||
          resume_req !== e.rdata[30] || hart_reset_req !== e.rdata[29] ||
          sys_reset_req !== e.rdata[1]) begin
        n_fails++;
        $display("FAIL %s: rdata=%h sel=%0d any=%b all=%b expected rdata=%h sel=%0d flag=%b",
                 e.tag, ctl_rdata, sel_hart, any_have_reset, all_have_reset,
                 e.rdata, e.sel, e.flag);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    m_active = 0; m_halt = 0; m_res = 0; m_hr = 0; m_sr = 0; m_sel = 0;
    for (int h = 0; h < NH; h++) m_flags[h] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step(0, '0, '0, "R1 reset state");
    step(1, mkw(1,0,0,0,0,0, 0, 3), '0, "R2 low field only, R5 first activation");
    step(1, mkw(1,0,0,0,0,0, 1, 5), '0, "R2 R3 high field above low");
    step(1, mkw(1,0,0,0,0,0, 10'h3FF, 10'h3FF), '0, "R2 mask to SEL_LEN, R3 split readback");
    step(1, mkw(1,0,1,0,1,1, 0, 2), '0, "R3 request bits readback");
    step(0, '0, 8'b0010_0100, "R6 pulses harts 2 and 5");
    step(1, mkw(0,0,0,1,0,0, 7, 9), '0, "R4 inactive write holds fields");
    step(1, mkw(0,1,0,0,0,0, 0, 2), '0, "R10 ack while inactive ignored");
    step(1, mkw(1,0,0,0,0,0, 0, 5), '0, "R5 restart clears flags");
    step(0, '0, 8'b0110_0100, "R6 pulses harts 2 5 6");
    step(1, mkw(1,1,0,0,0,0, 0, 5), '0, "R7 ack clears selected hart 5");
    step(1, mkw(1,0,0,0,0,0, 0, 6), '0, "R7 hart 6 flag kept");
    step(1, mkw(1,0,0,0,0,0, 0, 2), '0, "R7 hart 2 flag kept");
    step(1, mkw(1,1,0,0,0,0, 0, 6), 8'b0100_0000, "R9 pulse beats ack on hart 6");
    step(1, mkw(1,1,0,0,0,0, 0, 100), '0, "R8 index beyond last hart reads 0");
    step(1, mkw(1,0,0,0,0,0, 0, 2), '0, "R8 hart 2 flag still set");
    step(1, mkw(0,0,0,0,0,0, 0, 0), '0, "R4 deactivate");
    step(1, mkw(1,0,0,0,0,0, 0, 6), 8'b0000_1000, "R5 restart with hart 3 pulse");
    step(1, mkw(1,0,0,0,0,0, 0, 3), '0, "R5 R9 hart 3 kept through restart");
    step(1, mkw(1,0,0,0,0,0, 0, 2), '0, "R5 hart 2 cleared by restart");
    step(0, '0, '0, "R8 idle settle");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule